// File: doc/BRIEF.md
# Microcoded Multirate Allpass Decimator

This block turns a fast, oversampled stream of 16-bit two's complement samples from a low-resolution modulator into a signal at 1/128 of the input rate. It does this with seven halving stages. Each stage is a two-branch polyphase filter built from first-order recursive allpass sections. There are fifteen sections in all. They share a single multiply-accumulate unit, and each keeps its one state word in a 15-word state RAM. A nominal 1024 kHz input, meant for a band of about 3.4 kHz, comes out at 8 kHz.

Input words go into a small FIFO. A microsequencer reads horizontal microinstructions from a computed ROM, and each word drives the state RAM address, the coefficient select, the arithmetic operation and the register enables in the same cycle. The sequencer has three states. IDLE waits for the FIFO. RUN steps through microinstructions. EMIT presents a finished sample. Its transitions are as follows:
- IDLE to RUN when the FIFO is not empty. This pops one word and starts stage 1.
- RUN to IDLE on a branch-end word that parks a sample.
- RUN to RUN on a combine word below the last stage. This hands the result to the next stage.
- RUN to EMIT on a combine word in stage 7.
- EMIT to IDLE when `out_ready` is high.

Top module: `dec_allpass_decim`

## Requirements
- R1: The block produces exactly one output sample for every 128 input samples it accepts. `out_valid` stays low until the 128th sample after reset, or after the previous output, has been processed.
- R2: Each section has a state word s and a Q1.15 coefficient c, and uses floor division. For an input x it computes y = sat(s + floor(c·x/2^15)), then sets s = sat(x − floor(c·y/2^15)). Here sat clamps to the range −32768..32767.
- R3: Each stage alternates its input samples between branches, starting with branch A after reset. Branch A filters the sample and parks it. Branch B filters the next sample and emits floor((parked + filtered)/2) to the next stage, or to the output in stage 7.
- R4: Section coefficients are as follows. In stages 1 to 6, branch A uses 0x1000 and branch B uses 0x4C00. In stage 7, branch A is two sections in series, 0x0C00 then 0x5800, and branch B uses 0x3000. State words persist across samples.
- R5: Once `out_valid` is high, it stays high and `out_data` stays stable until a cycle with `out_ready` high. After that cycle, `out_valid` is low.
- R6: While an output waits, the sequencer takes no sample from the FIFO. Samples pushed meanwhile are kept and processed in arrival order afterwards.
- R7: The FIFO holds 4 words. A push into a full FIFO is dropped and sets `fifo_ovf`, which stays high until reset.
- R8: A synchronous reset clears all 15 state words, the parked samples, the FIFO and `fifo_ovf`. It sets `out_valid` low and returns the microprogram counter to 0. The next 128 inputs then give the same output as after power-up reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Push one input word into the FIFO |
| in_data | input | 16 | Input sample, two's complement |
| out_data | output | 16 | Decimated sample, two's complement |
| out_valid | output | 1 | Output sample is presented |
| out_ready | input | 1 | Consumer accepts the output sample |
| fifo_ovf | output | 1 | Sticky flag: a push met a full FIFO |

## Verification
Full-scale constant inputs of both signs drive every section into saturation. A design that wraps instead of clamping, or rounds instead of flooring, gives a different output word there. Mixed patterns expose a wrong branch order, a swapped coefficient or a lost state word through the carried state. The output is held back while samples are pushed, and then the FIFO is overfilled. A sequencer that keeps pulling, drops queued samples or misses the fifth push shows up as a wrong later output or a low flag. A reset in mid-stream is followed by a replay of the first pattern. Any state word or parked sample that survived the reset changes that replayed result.

// File: rtl/dec_pkg.sv
package dec_pkg;
    localparam int NSTG   = 7;
    localparam int NSEC   = 15;
    localparam int UWORDS = 44;
    localparam int UPCW   = 6;
    localparam int SECW   = $clog2(NSEC);
    localparam int STGW   = $clog2(NSTG);

    typedef enum logic [1:0] {OP_Y, OP_S, OP_PEND, OP_COMB} uop_e;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_EMIT} seq_e;

    typedef struct packed {
        uop_e            op;
        logic [SECW-1:0] sec;
    } uword_t;

    // entry point of the microroutine for one branch of one stage
    function automatic logic [UPCW-1:0] ustart(input logic [STGW-1:0] stg, input logic br);
        if (int'(stg) == NSTG - 1)
            return br ? UPCW'(41) : UPCW'(36);
        return UPCW'(6 * int'(stg) + (br ? 3 : 0));
    endfunction

    // horizontal microcode ROM, computed per address
    function automatic uword_t ucode(input logic [UPCW-1:0] a);
        uword_t w;
        int ai, k, r, b, wi;
        ai = int'(a);
        w.op  = OP_PEND;
        w.sec = '0;
        if (ai < 36) begin
            k  = ai / 6;
            r  = ai % 6;
            b  = r / 3;
            wi = r % 3;
            w.sec = SECW'(2 * k + b);
            if (wi == 0)      w.op = OP_Y;
            else if (wi == 1) w.op = OP_S;
            else              w.op = (b != 0) ? OP_COMB : OP_PEND;
        end else begin
            case (ai - 36)
                0: begin w.op = OP_Y;    w.sec = SECW'(12); end
                1: begin w.op = OP_S;    w.sec = SECW'(12); end
                2: begin w.op = OP_Y;    w.sec = SECW'(13); end
                3: begin w.op = OP_S;    w.sec = SECW'(13); end
                4: begin w.op = OP_PEND; w.sec = SECW'(13); end
                5: begin w.op = OP_Y;    w.sec = SECW'(14); end
                6: begin w.op = OP_S;    w.sec = SECW'(14); end
                7: begin w.op = OP_COMB; w.sec = SECW'(14); end
                default: begin w.op = OP_PEND; w.sec = '0; end
            endcase
        end
        return w;
    endfunction

    // per-section coefficient ROM, Q1.15
    function automatic logic signed [15:0] coef(input logic [SECW-1:0] s);
        int si;
        si = int'(s);
        if (si < 12) return (si % 2 != 0) ? 16'sh4C00 : 16'sh1000;
        if (si == 12) return 16'sh0C00;
        if (si == 13) return 16'sh5800;
        return 16'sh3000;
    endfunction
endpackage

// File: rtl/dec_fifo.sv
module dec_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          ovf
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          full, do_push, do_pop;

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= wp + 1'b1;
            end
            if (do_pop) rp <= rp + 1'b1;
            cnt <= cnt + (do_push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
            if (push && full) ovf <= 1'b1;
        end
    end

    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf);
    a_r7_ovf_set:    assert property (@(posedge clk) disable iff (rst) (push && full) |=> ovf);
    a_r6_no_underrun: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/dec_sram.sv
module dec_sram #(
    parameter int DW = 16,
    parameter int NW = 15,
    localparam int AW = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [NW];

    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NW; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    a_r4_addr_range: assert property (@(posedge clk) disable iff (rst) we |-> (int'(addr) < NW));
endmodule

// File: rtl/dec_mac.sv
module dec_mac #(
    parameter int DW = 16
) (
    input  logic                 upd,
    input  logic signed [DW-1:0] xin,
    input  logic signed [DW-1:0] yin,
    input  logic signed [DW-1:0] st,
    input  logic signed [DW-1:0] cf,
    output logic signed [DW-1:0] res
);
    localparam int PW = 2 * DW;
    localparam logic signed [PW-1:0] MAXV = PW'((1 << (DW - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic signed [DW-1:0] m, base;
    logic signed [PW-1:0] prod, base_w, sum;

    always_comb begin
        m      = upd ? yin : xin;
        base   = upd ? xin : st;
        prod   = m * cf;
        base_w = {{DW{base[DW-1]}}, base};
        sum    = upd ? (base_w - (prod >>> (DW - 1))) : (base_w + (prod >>> (DW - 1)));
        if (sum > MAXV)      res = MAXV[DW-1:0];
        else if (sum < MINV) res = MINV[DW-1:0];
        else                 res = DW'(sum);
    end

    always_comb begin
        a_r2_sat_range: assert (!((sum > MAXV) && (res != MAXV[DW-1:0])));
    end
endmodule

// File: rtl/dec_allpass_decim.sv
module dec_allpass_decim
    import dec_pkg::*;
#(
    parameter int DW         = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          fifo_ovf
);
    seq_e                 state, nstate;
    logic [UPCW-1:0]      upc;
    logic [STGW-1:0]      stg, nxt;
    logic signed [DW-1:0] xr, yr, mac_res, cmb;
    logic signed [DW:0]   csum;
    logic [DW-1:0]        fifo_dout, ram_rd;
    logic [NSTG-1:0]      pend;
    logic signed [DW-1:0] pv [NSTG];
    logic                 fifo_empty, pop, ram_we;
    uword_t               uw;

    assign uw  = ucode(upc);
    assign nxt = stg + 1'b1;
    assign pop = (state == ST_IDLE) && !fifo_empty;
    assign ram_we    = (state == ST_RUN) && (uw.op == OP_S);
    assign out_valid = (state == ST_EMIT);

    always_comb begin
        csum = {pv[stg][DW-1], pv[stg]} + {xr[DW-1], xr};
        cmb  = DW'(csum >>> 1);
    end

    dec_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(in_valid), .din(in_data),
        .pop(pop), .dout(fifo_dout), .empty(fifo_empty), .ovf(fifo_ovf)
    );

    dec_sram #(.DW(DW), .NW(NSEC)) u_sram (
        .clk(clk), .rst(rst), .we(ram_we), .addr(uw.sec),
        .wdata(mac_res), .rdata(ram_rd)
    );

    dec_mac #(.DW(DW)) u_mac (
        .upd(uw.op == OP_S), .xin(xr), .yin(yr), .st(ram_rd),
        .cf(DW'(coef(uw.sec))), .res(mac_res)
    );

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (!fifo_empty) nstate = ST_RUN;
            ST_RUN: begin
                if (uw.op == OP_PEND) nstate = ST_IDLE;
                else if (uw.op == OP_COMB && int'(stg) == NSTG - 1) nstate = ST_EMIT;
            end
            ST_EMIT: if (out_ready) nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nstate;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upc      <= '0;
            stg      <= '0;
            xr       <= '0;
            yr       <= '0;
            pend     <= '0;
            out_data <= '0;
            for (int i = 0; i < NSTG; i++) pv[i] <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (pop) begin
                    xr  <= fifo_dout;
                    stg <= '0;
                    upc <= ustart('0, pend[0]);
                end
                ST_RUN: begin
                    unique case (uw.op)
                        OP_Y: begin
                            yr  <= mac_res;
                            upc <= upc + 1'b1;
                        end
                        OP_S: begin
                            xr  <= yr;
                            upc <= upc + 1'b1;
                        end
                        OP_PEND: begin
                            pv[stg]   <= xr;
                            pend[stg] <= 1'b1;
                        end
                        OP_COMB: begin
                            pend[stg] <= 1'b0;
                            if (int'(stg) == NSTG - 1) begin
                                out_data <= cmb;
                            end else begin
                                xr  <= cmb;
                                stg <= nxt;
                                upc <= ustart(nxt, pend[nxt]);
                            end
                        end
                        default: upc <= upc;
                    endcase
                end
                ST_EMIT: upc <= upc;
                default: upc <= upc;
            endcase
        end
    end

    a_r5_hold_valid: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    a_r5_release:    assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> !out_valid);
    a_r6_no_pull:    assert property (@(posedge clk) disable iff (rst) out_valid |-> !pop);
    a_r3_upc_range:  assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (int'(upc) < UWORDS));
    a_r1_stage_range: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (int'(stg) < NSTG));
    a_r8_reset:      assert property (@(posedge clk)
        rst |=> (state == ST_IDLE && upc == '0 && !fifo_ovf));
endmodule

// File: tb/dec_allpass_decim_bench.sv
`timescale 1ns/1ps
module dec_allpass_decim_bench;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic signed [15:0] out_data;
    logic               out_valid;
    logic               out_ready = 1'b0;
    logic               fifo_ovf;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dec_allpass_decim u_dec_allpass_decim (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .fifo_ovf(fifo_ovf)
    );

    localparam int ROWS = 6;
    localparam logic signed [15:0] TA [ROWS] = '{16'sd16384, 16'sd32767, -16'sd32768, 16'sd0, 16'sd1000, 16'sd32767};
    localparam logic signed [15:0] TB [ROWS] = '{-16'sd16384, 16'sd32767, -16'sd32768, 16'sd0, -16'sd3000, -16'sd32768};

    // reference model built from R2, R3, R4
    int ms [15];
    bit mp [7];
    int mv [7];
    int mout;
    bit mhas;

    function automatic int msat(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int mcoef(input int s);
        if (s < 12) return (s % 2 != 0) ? 19456 : 4096;
        if (s == 12) return 3072;
        if (s == 13) return 22528;
        return 12288;
    endfunction

    function automatic int msec(input int s, input int x);
        int c, y;
        c = mcoef(s);
        y = msat(ms[s] + ((c * x) >>> 15));
        ms[s] = msat(x - ((c * y) >>> 15));
        return y;
    endfunction

    function automatic void mreset();
        for (int i = 0; i < 15; i++) ms[i] = 0;
        for (int i = 0; i < 7; i++) begin mp[i] = 1'b0; mv[i] = 0; end
        mhas = 1'b0;
        mout = 0;
    endfunction

    function automatic void mfeed(input int x);
        int v;
        v = x;
        for (int k = 0; k < 7; k++) begin
            if (!mp[k]) begin
                if (k < 6) v = msec(2 * k, v);
                else begin v = msec(12, v); v = msec(13, v); end
                mv[k] = v;
                mp[k] = 1'b1;
                return;
            end
            if (k < 6) v = msec(2 * k + 1, v);
            else       v = msec(14, v);
            v = (mv[k] + v) >>> 1;
            mp[k] = 1'b0;
            if (k == 6) begin mout = v; mhas = 1'b1; end
        end
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic signed [15:0] v, input int gap, input bit model);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = v;
        @(negedge clk);
        in_valid = 1'b0;
        if (model) mfeed(int'(v));
        repeat (gap) @(negedge clk);
    endtask

    task automatic handshake();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid == 1'b0, "R5 valid drops after ready", int'(out_valid), 0);
        mhas = 1'b0;
    endtask

    task automatic run_row(input logic signed [15:0] a, input logic signed [15:0] b, input string tag);
        for (int i = 0; i < 128; i++) begin
            if (i == 127) chk(out_valid == 1'b0, "R1 no output before 128th", int'(out_valid), 0);
            push((i % 2 != 0) ? b : a, 40, 1'b1);
        end
        chk(out_valid == 1'b1 && mhas, "R1 output after 128th", int'(out_valid), 1);
        chk(int'(out_data) == mout, tag, int'(out_data), mout);
        handshake();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic signed [15:0] held;
        mreset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 reset valid low", int'(out_valid), 0);
        chk(fifo_ovf == 1'b0, "R8 reset ovf low", int'(fifo_ovf), 0);

        // table of stimulus rows, expected words from the model (R2 R3 R4)
        for (int r = 0; r < ROWS; r++)
            run_row(TA[r], TB[r], "R2 R3 R4 row output");

        // back-pressure with queued samples (R5 R6)
        for (int i = 0; i < 128; i++)
            push(16'(((i * 2731) % 65536) - 32768), 40, 1'b1);
        chk(out_valid == 1'b1, "R5 output presented", int'(out_valid), 1);
        held = out_data;
        chk(int'(out_data) == mout, "R6 first stalled output", int'(out_data), mout);
        for (int i = 128; i < 131; i++)
            push(16'(((i * 2731) % 65536) - 32768), 40, 1'b1);
        chk(out_valid == 1'b1 && out_data == held, "R5 held while stalled", int'(out_data), int'(held));
        handshake();
        for (int i = 131; i < 256; i++)
            push(16'(((i * 2731) % 65536) - 32768), 40, 1'b1);
        chk(out_valid == 1'b1 && int'(out_data) == mout, "R6 order kept after stall", int'(out_data), mout);

        // overflow while stalled (R7)
        held = out_data;
        for (int i = 0; i < 4; i++) push(16'sd77, 2, 1'b0);
        chk(fifo_ovf == 1'b0, "R7 four pushes fit", int'(fifo_ovf), 0);
        push(16'sd77, 2, 1'b0);
        chk(fifo_ovf == 1'b1, "R7 fifth push overflows", int'(fifo_ovf), 1);
        chk(out_valid == 1'b1 && out_data == held, "R6 no pull during overflow", int'(out_data), int'(held));
        repeat (5) @(negedge clk);
        chk(fifo_ovf == 1'b1, "R7 flag sticky", int'(fifo_ovf), 1);

        // mid-stream reset and replay (R8)
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mreset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 valid low after reset", int'(out_valid), 0);
        chk(fifo_ovf == 1'b0, "R8 ovf cleared", int'(fifo_ovf), 0);
        run_row(TA[0], TB[0], "R8 replay after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule